// File: doc/BRIEF.md
# Deferred-Exception Commit Unit

This unit keeps the per-register deferred-fault flags of an integer and a floating-point register file, and a small log of faulting-load records, and resolves them when software commits or discards speculative results. A load that faulted without trapping reports itself on the deferral input. That sets the flag of its destination register and, while logging is active, writes a record holding the destination number, the register class and the faulting address into a chosen slot.

A later operation names either one register or the whole register file, together with the class and two enables that say whether the upper and lower halves of that file are currently accessible. A clear drops the selected flags and the matching records. A commit does the same, and also sends a one-cycle exception request if a selected flag was set and logging is active. A flush discards every record of one class and leaves the flags alone. All updates for an operation land on the same clock edge. The exception request is registered and appears in the following cycle.

Top module: `dxc_commit_unit`

## Requirements
- R1: After synchronous reset, every flag of both files is 0, every record is invalid and commit_exc is 0.
- R2: A deferral sets flag def_reg of the file picked by def_float (0 integer, 1 float) at the next edge. When def_rec is 1 and logging is active (ctl_valid and ctl_log_en both 1), the same edge writes record def_slot as valid with class def_float, destination def_reg and address def_addr.
- R3: A single-register operation (op_all 0, op_kind 0 clear or 1 commit) on an accessible register clears only that register's flag in the file picked by op_float. Flags of the other file and of other registers stay as they were.
- R4: An all-registers clear or commit (op_all 1) clears registers NREGS/2 and above of the selected file when hi_avail is 1, and registers below NREGS/2 when lo_avail is 1. A half whose enable is 0 keeps its flags.
- R5: A single-register operation whose register lies in an inaccessible half has no effect on flags, records or commit_exc. The upper half is op_reg bit RW-1 set, gated by hi_avail; the lower half is gated by lo_avail. An all-registers operation with both enables 0 has no effect either.
- R6: While logging is active, a clear, or a commit that finds a pending fault, invalidates every valid record whose class equals op_float and whose destination equals op_reg (any destination when op_all is 1), and zeroes its address.
- R7: While logging is inactive, clear, commit and flush leave every record as it was. Flags are still cleared as in R3 and R4.
- R8: commit_exc is 1 for exactly one cycle after a commit when logging is active and a fault was pending. For one register, pending means its flag was set. For all registers, pending means any set flag in an accessible half.
- R9: A commit that finds no pending fault leaves the records as they were and raises no request.
- R10: A flush (op_kind 2) with logging active invalidates every record of class op_float, whatever the availability enables. It leaves all flags unchanged and raises no request. Op code 3 has no effect.
- R11: When a deferral and an operation hit the same flag or record slot in the same cycle, the deferral's write takes effect.
- R12: rd_valid, rd_float, rd_dest and rd_addr show record rd_slot as it stands one cycle after rd_slot is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Logging control is valid |
| ctl_log_en | input | 1 | Logging of fault records enabled |
| def_valid | input | 1 | A deferred fault is reported this cycle |
| def_float | input | 1 | Class of the faulting destination (1 float) |
| def_reg | input | RW | Destination register of the faulting load |
| def_rec | input | 1 | Also write a log record |
| def_slot | input | SW | Record slot to write |
| def_addr | input | AW | Faulting address |
| op_valid | input | 1 | An operation is requested this cycle |
| op_kind | input | 2 | 0 clear, 1 commit, 2 flush, 3 none |
| op_all | input | 1 | Operate on every register of the file |
| op_float | input | 1 | Register file selected (1 float) |
| op_reg | input | RW | Target register when op_all is 0 |
| hi_avail | input | 1 | Upper half of the selected file accessible |
| lo_avail | input | 1 | Lower half of the selected file accessible |
| rd_slot | input | SW | Record slot to observe |
| ne_int | output | NREGS | Integer-file deferred-fault flags |
| ne_fp | output | NREGS | Float-file deferred-fault flags |
| commit_exc | output | 1 | Commit-exception request pulse |
| rd_valid | output | 1 | Observed record is valid |
| rd_float | output | 1 | Observed record class |
| rd_dest | output | RW | Observed record destination |
| rd_addr | output | AW | Observed record address |

## Verification
The assertions on flag clearing, unavailable targets and flush stability assume that no deferral writes the same file in that cycle, because R11 lets a deferral override an operation. Each property carries that exclusion in its antecedent. The directed stimulus keeps deferrals and operations in separate cycles everywhere except in the one scenario that exercises R11. The request assertions assume the logging controls are held steady around a commit, and the bench changes ctl_log_en only between operations.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR  = 2'd0,
    OP_COMMIT = 2'd1,
    OP_FLUSH  = 2'd2,
    OP_NONE   = 2'd3
  } op_kind_e;
endpackage

// File: rtl/dxc_op_decode.sv
module dxc_op_decode #(
  parameter int NREGS = 64
) (
  input  logic                     op_valid,
  input  logic [1:0]               op_kind,
  input  logic                     op_all,
  input  logic [$clog2(NREGS)-1:0] op_reg,
  input  logic                     hi_avail,
  input  logic                     lo_avail,
  output logic [NREGS-1:0]         sel_mask,
  output logic                     flag_op,
  output logic                     commit_op,
  output logic                     flush_op
);
  import dxc_pkg::*;
  localparam int RW   = $clog2(NREGS);
  localparam int HALF = NREGS / 2;

  op_kind_e            kind;
  logic                in_range;
  logic                flag_kind;
  logic [NREGS-1:0]    one_hot;

  assign kind      = op_kind_e'(op_kind);
  assign flag_kind = (kind == OP_CLEAR) || (kind == OP_COMMIT);
  assign one_hot   = {{(NREGS-1){1'b0}}, 1'b1} << op_reg;

  // The target half decides accessibility; all-register requests need either half.
  always_comb begin
    if (op_all) in_range = hi_avail | lo_avail;
    else        in_range = op_reg[RW-1] ? hi_avail : lo_avail;
  end

  assign flag_op   = op_valid && flag_kind && in_range;
  assign commit_op = flag_op && (kind == OP_COMMIT);
  assign flush_op  = op_valid && (kind == OP_FLUSH);

  always_comb begin
    if (!flag_op)    sel_mask = '0;
    else if (op_all) sel_mask = {{HALF{hi_avail}}, {HALF{lo_avail}}};
    else             sel_mask = one_hot;
  end
endmodule

// File: rtl/dxc_flag_bank.sv
module dxc_flag_bank #(
  parameter int NREGS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     set_en,
  input  logic [$clog2(NREGS)-1:0] set_idx,
  input  logic                     clr_en,
  input  logic [NREGS-1:0]         clr_mask,
  output logic [NREGS-1:0]         flags,
  output logic                     pending
);
  logic [NREGS-1:0] flags_q;
  logic [NREGS-1:0] set_vec;
  logic [NREGS-1:0] clr_vec;

  assign set_vec = set_en ? ({{(NREGS-1){1'b0}}, 1'b1} << set_idx) : '0;
  assign clr_vec = clr_en ? clr_mask : '0;
  assign pending = |(flags_q & clr_vec);

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  assign flags = flags_q;
endmodule

// File: rtl/dxc_log_bank.sv
module dxc_log_bank #(
  parameter int NREC  = 8,
  parameter int NREGS = 64,
  parameter int AW    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(NREC)-1:0]  wr_slot,
  input  logic                     wr_float,
  input  logic [$clog2(NREGS)-1:0] wr_dest,
  input  logic [AW-1:0]            wr_addr,
  input  logic                     clr_en,
  input  logic                     clr_float,
  input  logic                     clr_all,
  input  logic [$clog2(NREGS)-1:0] clr_dest,
  input  logic [$clog2(NREC)-1:0]  rd_slot,
  output logic                     rd_valid,
  output logic                     rd_float,
  output logic [$clog2(NREGS)-1:0] rd_dest,
  output logic [AW-1:0]            rd_addr
);
  localparam int RW = $clog2(NREGS);

  logic [NREC-1:0] vld_q;
  logic [NREC-1:0] flt_q;
  logic [RW-1:0]   dst_q [NREC];
  logic [AW-1:0]   adr_q [NREC];

  for (genvar i = 0; i < NREC; i++) begin : g_slot
    logic hit;
    logic wr_here;
    assign hit = vld_q[i] && (flt_q[i] == clr_float) && (clr_all || (dst_q[i] == clr_dest));
    assign wr_here = wr_en && (wr_slot == i);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[i] <= 1'b0;
        flt_q[i] <= 1'b0;
        dst_q[i] <= '0;
        adr_q[i] <= '0;
      end else if (wr_here) begin
        vld_q[i] <= 1'b1;
        flt_q[i] <= wr_float;
        dst_q[i] <= wr_dest;
        adr_q[i] <= wr_addr;
      end else if (clr_en && hit) begin
        vld_q[i] <= 1'b0;
        flt_q[i] <= 1'b0;
        dst_q[i] <= '0;
        adr_q[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_float <= 1'b0;
      rd_dest  <= '0;
      rd_addr  <= '0;
    end else begin
      rd_valid <= vld_q[rd_slot];
      rd_float <= flt_q[rd_slot];
      rd_dest  <= dst_q[rd_slot];
      rd_addr  <= adr_q[rd_slot];
    end
  end
endmodule

// File: rtl/dxc_commit_unit.sv
module dxc_commit_unit #(
  parameter int NREGS = 64,
  parameter int NREC  = 8,
  parameter int AW    = 32,
  localparam int RW   = $clog2(NREGS),
  localparam int SW   = $clog2(NREC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_valid,
  input  logic             ctl_log_en,
  input  logic             def_valid,
  input  logic             def_float,
  input  logic [RW-1:0]    def_reg,
  input  logic             def_rec,
  input  logic [SW-1:0]    def_slot,
  input  logic [AW-1:0]    def_addr,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic             op_all,
  input  logic             op_float,
  input  logic [RW-1:0]    op_reg,
  input  logic             hi_avail,
  input  logic             lo_avail,
  input  logic [SW-1:0]    rd_slot,
  output logic [NREGS-1:0] ne_int,
  output logic [NREGS-1:0] ne_fp,
  output logic             commit_exc,
  output logic             rd_valid,
  output logic             rd_float,
  output logic [RW-1:0]    rd_dest,
  output logic [AW-1:0]    rd_addr
);
  logic [NREGS-1:0] sel_mask;
  logic             flag_op;
  logic             commit_op;
  logic             flush_op;
  logic             log_on;
  logic [1:0]       pend;
  logic             pending;
  logic             rec_clr;
  logic             exc_q;
  logic [NREGS-1:0] bank_flags [2];

  dxc_op_decode #(.NREGS(NREGS)) i_decode (
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_all   (op_all),
    .op_reg   (op_reg),
    .hi_avail (hi_avail),
    .lo_avail (lo_avail),
    .sel_mask (sel_mask),
    .flag_op  (flag_op),
    .commit_op(commit_op),
    .flush_op (flush_op)
  );

  // Bank 0 holds the integer file, bank 1 the float file.
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic mine_set;
    logic mine_clr;
    assign mine_set = def_valid && (def_float == g[0]);
    assign mine_clr = flag_op && (op_float == g[0]);
    dxc_flag_bank #(.NREGS(NREGS)) i_flags (
      .clk     (clk),
      .rst     (rst),
      .set_en  (mine_set),
      .set_idx (def_reg),
      .clr_en  (mine_clr),
      .clr_mask(sel_mask),
      .flags   (bank_flags[g]),
      .pending (pend[g])
    );
  end

  assign log_on  = ctl_valid && ctl_log_en;
  assign pending = op_float ? pend[1] : pend[0];
  assign rec_clr = log_on && (flush_op || (flag_op && (!commit_op || pending)));

  dxc_log_bank #(.NREC(NREC), .NREGS(NREGS), .AW(AW)) i_log (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (def_valid && def_rec && log_on),
    .wr_slot  (def_slot),
    .wr_float (def_float),
    .wr_dest  (def_reg),
    .wr_addr  (def_addr),
    .clr_en   (rec_clr),
    .clr_float(op_float),
    .clr_all  (op_all || flush_op),
    .clr_dest (op_reg),
    .rd_slot  (rd_slot),
    .rd_valid (rd_valid),
    .rd_float (rd_float),
    .rd_dest  (rd_dest),
    .rd_addr  (rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) exc_q <= 1'b0;
    else     exc_q <= commit_op && log_on && pending;
  end

  assign ne_int     = bank_flags[0];
  assign ne_fp      = bank_flags[1];
  assign commit_exc = exc_q;
endmodule

// File: rtl/dxc_commit_checker.sv
module dxc_commit_checker #(
  parameter int NREGS = 64,
  localparam int RW   = $clog2(NREGS)
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_valid,
  input logic             ctl_log_en,
  input logic             def_valid,
  input logic             def_float,
  input logic [RW-1:0]    def_reg,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic             op_all,
  input logic             op_float,
  input logic [RW-1:0]    op_reg,
  input logic             hi_avail,
  input logic             lo_avail,
  input logic [NREGS-1:0] ne_int,
  input logic [NREGS-1:0] ne_fp,
  input logic             commit_exc
);
  logic tgt_avail;
  logic flag_kind;
  assign tgt_avail = op_reg[RW-1] ? hi_avail : lo_avail;
  assign flag_kind = (op_kind == 2'd0) || (op_kind == 2'd1);

  assert_defer_sets_R2: assert property (@(posedge clk) disable iff (rst)
    def_valid |=> (($past(def_float) ? ne_fp[$past(def_reg)] : ne_int[$past(def_reg)]) == 1'b1));

  assert_single_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && flag_kind && !op_all && !op_float && tgt_avail && !def_valid)
      |=> (ne_int[$past(op_reg)] == 1'b0) && $stable(ne_fp));

  assert_unavail_inert_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_all && !tgt_avail && !def_valid)
      |=> $stable(ne_int) && $stable(ne_fp) && !commit_exc);

  assert_exc_source_R8: assert property (@(posedge clk) disable iff (rst)
    commit_exc |-> $past(op_valid && op_kind == 2'd1 && ctl_valid && ctl_log_en));

  assert_exc_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (commit_exc && !(op_valid && op_kind == 2'd1)) |=> !commit_exc);

  assert_flush_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd2 && !def_valid)
      |=> $stable(ne_int) && $stable(ne_fp) && !commit_exc);
endmodule

bind dxc_commit_unit dxc_commit_checker #(.NREGS(NREGS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_valid (ctl_valid),
  .ctl_log_en(ctl_log_en),
  .def_valid (def_valid),
  .def_float (def_float),
  .def_reg   (def_reg),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .op_all    (op_all),
  .op_float  (op_float),
  .op_reg    (op_reg),
  .hi_avail  (hi_avail),
  .lo_avail  (lo_avail),
  .ne_int    (ne_int),
  .ne_fp     (ne_fp),
  .commit_exc(commit_exc)
);

// File: tb/test_dxc_commit_unit.sv
`timescale 1ns/1ps
module test_dxc_commit_unit;
  localparam int NREGS = 64;
  localparam int NREC  = 8;
  localparam int AW    = 32;
  localparam int RW    = $clog2(NREGS);
  localparam int SW    = $clog2(NREC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_valid = 1'b1, ctl_log_en = 1'b1;
  logic def_valid = 1'b0, def_float = 1'b0, def_rec = 1'b0;
  logic [RW-1:0] def_reg = '0;
  logic [SW-1:0] def_slot = '0;
  logic [AW-1:0] def_addr = '0;
  logic op_valid = 1'b0, op_all = 1'b0, op_float = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [RW-1:0] op_reg = '0;
  logic hi_avail = 1'b1, lo_avail = 1'b1;
  logic [SW-1:0] rd_slot = '0;
  logic [NREGS-1:0] ne_int, ne_fp;
  logic commit_exc, rd_valid, rd_float;
  logic [RW-1:0] rd_dest;
  logic [AW-1:0] rd_addr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dxc_commit_unit #(.NREGS(NREGS), .NREC(NREC), .AW(AW)) i_dxc_commit_unit (
    .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .ctl_log_en(ctl_log_en),
    .def_valid(def_valid), .def_float(def_float), .def_reg(def_reg),
    .def_rec(def_rec), .def_slot(def_slot), .def_addr(def_addr),
    .op_valid(op_valid), .op_kind(op_kind), .op_all(op_all),
    .op_float(op_float), .op_reg(op_reg), .hi_avail(hi_avail),
    .lo_avail(lo_avail), .rd_slot(rd_slot), .ne_int(ne_int), .ne_fp(ne_fp),
    .commit_exc(commit_exc), .rd_valid(rd_valid), .rd_float(rd_float),
    .rd_dest(rd_dest), .rd_addr(rd_addr)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic defer(input logic f, input int r, input logic rec,
                       input int s, input logic [AW-1:0] a);
    @(negedge clk);
    def_valid = 1'b1; def_float = f; def_reg = RW'(r);
    def_rec = rec; def_slot = SW'(s); def_addr = a;
    @(negedge clk);
    def_valid = 1'b0; def_rec = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] k, input logic all, input logic f,
                       input int r, input logic hi, input logic lo,
                       output logic exc);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_all = all; op_float = f;
    op_reg = RW'(r); hi_avail = hi; lo_avail = lo;
    @(negedge clk);
    exc = commit_exc;
    op_valid = 1'b0; hi_avail = 1'b1; lo_avail = 1'b1;
  endtask

  // R12: the record view is registered, sampled one cycle after rd_slot.
  task automatic check_rec(input string tag, input int s, input logic v,
                           input logic f, input int d, input logic [AW-1:0] a);
    @(negedge clk);
    rd_slot = SW'(s);
    @(negedge clk);
    check(tag, $sformatf("slot%0d valid", s), 64'(rd_valid), 64'(v));
    if (v) begin
      check(tag, $sformatf("slot%0d class", s), 64'(rd_float), 64'(f));
      check(tag, $sformatf("slot%0d dest", s), 64'(rd_dest), 64'(d));
      check(tag, $sformatf("slot%0d addr", s), 64'(rd_addr), 64'(a));
    end else begin
      check(tag, $sformatf("slot%0d addr zero", s), 64'(rd_addr), 64'd0);
    end
  endtask

  task automatic t_reset;
    check("R1", "ne_int", ne_int, 64'd0);
    check("R1", "ne_fp", ne_fp, 64'd0);
    check("R1", "commit_exc", 64'(commit_exc), 64'd0);
    check_rec("R1", 0, 1'b0, 1'b0, 0, '0);
    check_rec("R1", 7, 1'b0, 1'b0, 0, '0);
  endtask

  task automatic t_defer;
    defer(1'b0, 5, 1'b1, 0, 32'hA000_0010);
    defer(1'b1, 40, 1'b1, 1, 32'hB000_0020);
    defer(1'b0, 40, 1'b1, 2, 32'hC000_0030);
    defer(1'b0, 3, 1'b0, 5, 32'hDEAD_0000);
    check("R2", "ne_int", ne_int, (64'd1 << 5) | (64'd1 << 40) | (64'd1 << 3));
    check("R2", "ne_fp", ne_fp, 64'd1 << 40);
    check_rec("R2", 0, 1'b1, 1'b0, 5, 32'hA000_0010);
    check_rec("R2", 1, 1'b1, 1'b1, 40, 32'hB000_0020);
    check_rec("R2", 5, 1'b0, 1'b0, 0, '0);
  endtask

  task automatic t_single_clear;
    logic exc;
    do_op(2'd0, 1'b0, 1'b0, 40, 1'b1, 1'b0, exc);
    check("R3", "ne_int after clear 40", ne_int, (64'd1 << 5) | (64'd1 << 3));
    check("R3", "ne_fp untouched", ne_fp, 64'd1 << 40);
    check("R3", "clear raises nothing", 64'(exc), 64'd0);
    check_rec("R6", 2, 1'b0, 1'b0, 0, '0);
    check_rec("R6", 1, 1'b1, 1'b1, 40, 32'hB000_0020);
    check_rec("R6", 0, 1'b1, 1'b0, 5, 32'hA000_0010);
  endtask

  task automatic t_unavail;
    logic exc;
    do_op(2'd1, 1'b0, 1'b0, 5, 1'b1, 1'b0, exc);
    check("R5", "commit_exc", 64'(exc), 64'd0);
    check("R5", "ne_int kept", ne_int, (64'd1 << 5) | (64'd1 << 3));
    check_rec("R5", 0, 1'b1, 1'b0, 5, 32'hA000_0010);
    do_op(2'd0, 1'b1, 1'b0, 0, 1'b0, 1'b0, exc);
    check("R5", "all with no half", ne_int, (64'd1 << 5) | (64'd1 << 3));
  endtask

  task automatic t_commit;
    logic exc;
    do_op(2'd1, 1'b0, 1'b0, 5, 1'b0, 1'b1, exc);
    check("R8", "commit pending raises", 64'(exc), 64'd1);
    check("R3", "ne_int after commit 5", ne_int, 64'd1 << 3);
    @(negedge clk);
    check("R8", "pulse one cycle", 64'(commit_exc), 64'd0);
    check_rec("R6", 0, 1'b0, 1'b0, 0, '0);
    do_op(2'd1, 1'b0, 1'b0, 5, 1'b1, 1'b1, exc);
    check("R8", "no pending no request", 64'(exc), 64'd0);
  endtask

  task automatic t_log_off;
    logic exc;
    defer(1'b0, 7, 1'b1, 3, 32'h0000_7777);
    ctl_log_en = 1'b0;
    do_op(2'd0, 1'b0, 1'b0, 7, 1'b1, 1'b1, exc);
    check("R7", "flag cleared", 64'(ne_int[7]), 64'd0);
    check_rec("R7", 3, 1'b1, 1'b0, 7, 32'h0000_7777);
    defer(1'b0, 10, 1'b0, 0, '0);
    do_op(2'd1, 1'b0, 1'b0, 10, 1'b1, 1'b1, exc);
    check("R8", "logging off no request", 64'(exc), 64'd0);
    check("R7", "flag 10 cleared", 64'(ne_int[10]), 64'd0);
    ctl_log_en = 1'b1;
    do_op(2'd1, 1'b0, 1'b0, 7, 1'b1, 1'b1, exc);
    check("R9", "no request", 64'(exc), 64'd0);
    check_rec("R9", 3, 1'b1, 1'b0, 7, 32'h0000_7777);
  endtask

  task automatic t_all;
    logic exc;
    defer(1'b0, 2, 1'b0, 0, '0);
    defer(1'b0, 50, 1'b0, 0, '0);
    do_op(2'd1, 1'b1, 1'b0, 0, 1'b1, 1'b0, exc);
    check("R8", "upper half pending", 64'(exc), 64'd1);
    check("R4", "upper cleared only", ne_int, (64'd1 << 2) | (64'd1 << 3));
    check("R4", "fp file untouched", ne_fp, 64'd1 << 40);
    check_rec("R6", 3, 1'b0, 1'b0, 0, '0);
    check_rec("R6", 1, 1'b1, 1'b1, 40, 32'hB000_0020);
    do_op(2'd1, 1'b1, 1'b0, 0, 1'b0, 1'b1, exc);
    check("R8", "lower half pending", 64'(exc), 64'd1);
    check("R4", "lower cleared", ne_int, 64'd0);
  endtask

  task automatic t_flush;
    logic exc;
    defer(1'b0, 9, 1'b1, 4, 32'h0000_0909);
    do_op(2'd2, 1'b0, 1'b1, 0, 1'b0, 1'b0, exc);
    check("R10", "flush no request", 64'(exc), 64'd0);
    check("R10", "fp flags kept", ne_fp, 64'd1 << 40);
    check("R10", "int flags kept", ne_int, 64'd1 << 9);
    check_rec("R10", 1, 1'b0, 1'b0, 0, '0);
    check_rec("R10", 4, 1'b1, 1'b0, 9, 32'h0000_0909);
    do_op(2'd3, 1'b0, 1'b0, 9, 1'b1, 1'b1, exc);
    check("R10", "op 3 inert", ne_int, 64'd1 << 9);
    check_rec("R10", 4, 1'b1, 1'b0, 9, 32'h0000_0909);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'd0; op_all = 1'b0; op_float = 1'b0; op_reg = RW'(9);
    def_valid = 1'b1; def_float = 1'b0; def_reg = RW'(9);
    def_rec = 1'b1; def_slot = SW'(4); def_addr = 32'h0000_1234;
    @(negedge clk);
    op_valid = 1'b0; def_valid = 1'b0; def_rec = 1'b0;
    check("R11", "flag kept set", 64'(ne_int[9]), 64'd1);
    check_rec("R11", 4, 1'b1, 1'b0, 9, 32'h0000_1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_defer;
    t_single_clear;
    t_unavail;
    t_commit;
    t_log_off;
    t_all;
    t_flush;
    t_same_cycle;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule